// File: doc/BRIEF.md
# Receive 64B/66B Block Gearbox with Bit Slip

This block takes a continuous stream of received bits, delivered a parallel word per clock with the earliest bit in the least significant position. It cuts the stream into coded blocks of a 64-bit payload behind a short sync header. The header is 2 bits in 64B/66B mode and 3 bits in 64B/67B mode. Each block goes out on a parallel interface as a header field and payload words, with strobes that mark which cycles carry payload and which carry a header.

The parameter `DW` sets the interface width to 32 or 64 bits. At 64 bits, a whole block leaves in one cycle. At 32 bits, a block leaves as two words, and only the first word carries the header. The block length is longer than the interface width, so on some cycles there are not enough buffered bits to form output, and the payload strobe drops on those cycles.

A lock search outside this block drives the slip input. Each accepted slip discards one received bit, which moves the block boundary one bit later. A counter reports how many bit positions the boundary has moved, modulo the block length.

Top module: `gbx_rx_top`

## Requirements
- R1: Bits are assembled least significant first. The first received bits of a block form the header, with the earliest bit in `blk_hdr[0]`. In 64B/66B mode, `blk_hdr[2]` reads 0. The first payload bit is the bit received right after the header and appears in bit 0 of the payload.
- R2: With `DW`=64, every cycle with `data_vld` high carries one whole block, and `hdr_vld` equals `data_vld`.
- R3: With `DW`=32, each block leaves as two payload words. `hdr_vld` is high on the first word and low on the second, so across payload cycles it toggles.
- R4: `data_vld` is high exactly when enough unconsumed bits are buffered for the next output word. With `DW`=64 and no slip, any 33 consecutive cycles in 64B/66B mode hold exactly 32 payload cycles, and any 67 consecutive cycles in 64B/67B mode hold exactly 64.
- R5: A rising edge on `slip_req` discards the oldest buffered bit in that cycle, so the block boundary moves one bit later in the stream.
- R6: Holding `slip_req` high gives only one slip. It must be low for at least one cycle before another slip is accepted.
- R7: `align_pos` counts accepted slips from 0 and wraps from 65 to 0 in 64B/66B mode, and from 66 to 0 in 64B/67B mode.
- R8: When `mode67` is 1, the header is 3 bits and `blk_hdr[2]` holds the third received bit of the block. `mode67` may change only while `rst` is high.
- R9: A synchronous reset empties the buffer, clears all outputs and strobes, and returns `align_pos` to 0.
- R10: Outputs are registered. A word appears on the clock edge that ends the cycle in which its last input bit was presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode67 | input | 1 | 0 selects 64B/66B, 1 selects 64B/67B |
| rx_bits | input | DW | Received bits, earliest in bit 0 |
| slip_req | input | 1 | Slip request, acted on at its rising edge |
| blk_data | output | DW | Payload word |
| blk_hdr | output | 3 | Sync header, earliest bit in bit 0 |
| hdr_vld | output | 1 | `blk_hdr` belongs to the current word |
| data_vld | output | 1 | `blk_data` carries payload this cycle |
| align_pos | output | 7 | Accepted slips modulo the block length |

## Verification
The bench runs a 64-bit and a 32-bit instance side by side against a bit-queue model. This catches a design that reads a header from the wrong bit position or splits the half-block words off by a bit, because payload and header words then differ from the model. A held slip input is a key case: a level-sensitive slip would move `align_pos` and shift the data several positions instead of one. Runs of 66 and 67 pulses check the wrap, since a counter that wraps at the wrong length ends away from its start. Counted windows of payload cycles expose pacing that idles too often or too rarely.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

  // header width for the selected coding
  function automatic logic [7:0] hdr_len(input logic m67);
    return m67 ? 8'd3 : 8'd2;
  endfunction

  // total coded block length
  function automatic logic [7:0] blk_len(input logic m67);
    return 8'd64 + hdr_len(m67);
  endfunction

  // bits consumed by the next output word
  function automatic logic [7:0] need_bits(input logic m67, input int dw, input logic second);
    if (dw == 64) return blk_len(m67);
    return second ? 8'd32 : (hdr_len(m67) + 8'd32);
  endfunction

endpackage

// File: rtl/gbx_slip_ctl.sv
module gbx_slip_ctl
  import gbx_pkg::*;
#(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode67,
  input  logic             slip_req,
  output logic             slip_take,
  output logic [POS_W-1:0] pos
);

  logic slip_q;
  logic at_last;

  assign slip_take = slip_req & ~slip_q;
  assign at_last   = (pos == POS_W'(blk_len(mode67) - 8'd1));

  always_ff @(posedge clk) begin
    if (rst) begin
      slip_q <= 1'b0;
      pos    <= '0;
    end else begin
      slip_q <= slip_req;
      if (slip_take) pos <= at_last ? '0 : pos + 1'b1;
    end
  end

  // a held request moves nothing after its first cycle
  assert_slip_once_R6: assert property (@(posedge clk) disable iff (rst)
    (slip_req && slip_q) |=> (pos == $past(pos)));

  // position stays inside one block length
  assert_pos_range_R7: assert property (@(posedge clk) disable iff (rst)
    (8'(pos) < blk_len(mode67)));

endmodule

// File: rtl/gbx_shift_buf.sv
module gbx_shift_buf
  import gbx_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode67,
  input  logic [DW-1:0] rx_bits,
  input  logic          slip_take,
  output logic          emit,
  output logic          first_word,
  output logic [2:0]    word_hdr,
  output logic [DW-1:0] word_data
);

  localparam int BUF_W = 2 * DW + 4;
  localparam int CW    = $clog2(BUF_W + 1);
  localparam int WORDS = 64 / DW;

  logic [BUF_W-1:0] buf_q, merged, shifted;
  logic [CW-1:0]    cnt_q, avail, need, hl;
  logic             phase_q;

  generate
    if (WORDS == 2) begin : g_half
      always_ff @(posedge clk) begin
        if (rst)       phase_q <= 1'b0;
        else if (emit) phase_q <= ~phase_q;
      end
    end else begin : g_full
      assign phase_q = 1'b0;
    end
  endgenerate

  assign first_word = ~phase_q;
  assign hl         = CW'(hdr_len(mode67));
  assign need       = CW'(need_bits(mode67, DW, phase_q));

  // new bits land just above the valid fill
  assign merged  = buf_q | (BUF_W'(rx_bits) << cnt_q);
  assign shifted = slip_take ? (merged >> 1) : merged;
  assign avail   = cnt_q + CW'(DW) - CW'(slip_take);
  assign emit    = (avail >= need);

  assign word_hdr  = mode67 ? shifted[2:0] : {1'b0, shifted[1:0]};
  assign word_data = first_word ? DW'(shifted >> hl) : shifted[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (emit) begin
      buf_q <= shifted >> need;
      cnt_q <= avail - need;
    end else begin
      buf_q <= shifted;
      cnt_q <= avail;
    end
  end

  // fill never reaches a word's worth between cycles
  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q < CW'(need_bits(mode67, DW, phase_q))));

endmodule

// File: rtl/gbx_rx_top.sv
module gbx_rx_top
  import gbx_pkg::*;
#(
  parameter int DW    = 64,
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode67,
  input  logic [DW-1:0]    rx_bits,
  input  logic             slip_req,
  output logic [DW-1:0]    blk_data,
  output logic [2:0]       blk_hdr,
  output logic             hdr_vld,
  output logic             data_vld,
  output logic [POS_W-1:0] align_pos
);

  logic          slip_take;
  logic          emit;
  logic          first_word;
  logic [2:0]    word_hdr;
  logic [DW-1:0] word_data;

  gbx_slip_ctl #(.POS_W(POS_W)) u_slip (
    .clk       (clk),
    .rst       (rst),
    .mode67    (mode67),
    .slip_req  (slip_req),
    .slip_take (slip_take),
    .pos       (align_pos)
  );

  gbx_shift_buf #(.DW(DW)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .mode67     (mode67),
    .rx_bits    (rx_bits),
    .slip_take  (slip_take),
    .emit       (emit),
    .first_word (first_word),
    .word_hdr   (word_hdr),
    .word_data  (word_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_data <= '0;
      blk_hdr  <= '0;
      hdr_vld  <= 1'b0;
      data_vld <= 1'b0;
    end else begin
      data_vld <= emit;
      hdr_vld  <= emit & first_word;
      if (emit)              blk_data <= word_data;
      if (emit & first_word) blk_hdr  <= word_hdr;
    end
  end

  assert_hdr_needs_data_R2: assert property (@(posedge clk) disable iff (rst)
    hdr_vld |-> data_vld);

  assert_hdr_bit2_clear_R1: assert property (@(posedge clk) disable iff (rst)
    (hdr_vld && !mode67) |-> (blk_hdr[2] == 1'b0));

  generate
    if (DW == 64) begin : g_chk_full
      assert_whole_block_R2: assert property (@(posedge clk) disable iff (rst)
        data_vld |-> hdr_vld);
    end else begin : g_chk_half
      assert_hdr_alternate_R3: assert property (@(posedge clk) disable iff (rst)
        hdr_vld |=> !hdr_vld);
    end
  endgenerate

endmodule

// File: tb/sim_gbx_rx_top.sv
module sim_gbx_rx_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, mode67, slip;
  logic [63:0] din64;
  logic [31:0] din32;

  logic [63:0] d0;  logic [2:0] h0;  logic hv0, dv0;  logic [6:0] p0;
  logic [31:0] d1;  logic [2:0] h1;  logic hv1, dv1;  logic [6:0] p1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gbx_rx_top #(.DW(64)) u0 (
    .clk(clk), .rst(rst), .mode67(mode67), .rx_bits(din64), .slip_req(slip),
    .blk_data(d0), .blk_hdr(h0), .hdr_vld(hv0), .data_vld(dv0), .align_pos(p0));

  gbx_rx_top #(.DW(32)) u1 (
    .clk(clk), .rst(rst), .mode67(mode67), .rx_bits(din32), .slip_req(slip),
    .blk_data(d1), .blk_hdr(h1), .hdr_vld(hv1), .data_vld(dv1), .align_pos(p1));

  // behavioural model: a bit queue per instance
  logic        rb  [2][256];
  int          wr  [2];
  int          rd  [2];
  int          ph  [2];
  int          pos_m;
  bit          slip_prev;
  bit          last_rst;
  logic        edv [2];
  logic        ehv [2];
  logic [63:0] edata [2];
  logic [2:0]  ehdr  [2];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input logic r, input logic m, input logic [63:0] a, input logic [31:0] b, input logic s);
    int bl, hl, need, off, dw;
    bit acc, first;
    if (r) begin
      for (int k = 0; k < 2; k++) begin
        wr[k] = 0; rd[k] = 0; ph[k] = 0;
        edv[k] = 0; ehv[k] = 0; edata[k] = '0; ehdr[k] = '0;
      end
      pos_m = 0; slip_prev = 0;
      return;
    end
    acc = s && !slip_prev;
    slip_prev = s;
    bl = m ? 67 : 66;
    hl = m ? 3 : 2;
    if (acc) pos_m = (pos_m + 1) % bl;
    for (int k = 0; k < 2; k++) begin
      dw = (k == 0) ? 64 : 32;
      for (int i = 0; i < dw; i++) begin
        rb[k][wr[k] % 256] = (k == 0) ? a[i] : b[i];
        wr[k]++;
      end
      if (acc) rd[k]++;
      need = (dw == 64) ? bl : ((ph[k] == 0) ? hl + 32 : 32);
      edv[k] = 0;
      ehv[k] = 0;
      if (wr[k] - rd[k] >= need) begin
        edv[k] = 1;
        first = (dw == 64) || (ph[k] == 0);
        off = 0;
        if (first) begin
          ehv[k] = 1;
          ehdr[k] = '0;
          for (int i = 0; i < hl; i++) ehdr[k][i] = rb[k][(rd[k] + i) % 256];
          off = hl;
        end
        edata[k] = '0;
        for (int i = 0; i < dw; i++) edata[k][i] = rb[k][(rd[k] + off + i) % 256];
        rd[k] += need;
        if (dw == 32) ph[k] ^= 1;
      end
    end
  endtask

  task automatic compare();
    string pre;
    pre = last_rst ? "R9 " : "";
    chk(dv0 == edv[0], {pre, "R4 R10 w64 data_vld"}, 64'(dv0), 64'(edv[0]));
    chk(hv0 == ehv[0], {pre, "R2 w64 hdr_vld"}, 64'(hv0), 64'(ehv[0]));
    chk(dv1 == edv[1], {pre, "R4 R10 w32 data_vld"}, 64'(dv1), 64'(edv[1]));
    chk(hv1 == ehv[1], {pre, "R3 w32 hdr_vld"}, 64'(hv1), 64'(ehv[1]));
    chk(p0 == 7'(pos_m), {pre, "R7 w64 align_pos"}, 64'(p0), 64'(pos_m));
    chk(p1 == 7'(pos_m), {pre, "R7 w32 align_pos"}, 64'(p1), 64'(pos_m));
    if (edv[0]) chk(d0 == edata[0], "R1 R5 w64 payload", d0, edata[0]);
    if (edv[1]) chk(d1 == edata[1][31:0], "R1 R5 w32 payload", 64'(d1), 64'(edata[1][31:0]));
    if (ehv[0]) chk(h0 == ehdr[0], mode67 ? "R8 w64 header" : "R1 w64 header", 64'(h0), 64'(ehdr[0]));
    if (ehv[1]) chk(h1 == ehdr[1], mode67 ? "R8 w32 header" : "R1 w32 header", 64'(h1), 64'(ehdr[1]));
  endtask

  task automatic cyc(input logic r, input logic m, input logic s);
    logic [63:0] a;
    logic [31:0] b;
    a = {$urandom, $urandom};
    b = $urandom;
    rst = r; mode67 = m; slip = s; din64 = a; din32 = b;
    model(r, m, a, b, s);
    last_rst = r;
    @(negedge clk);
    compare();
  endtask

  task automatic run_mode(input logic m);
    int cnt, pb, bl;
    bl = m ? 67 : 66;
    cyc(1, m, 0);
    cyc(1, m, 0);
    repeat (100) cyc(0, m, 0);
    // R4 pacing window on the 64-bit instance
    cnt = 0;
    repeat (bl == 66 ? 33 : 67) begin
      cyc(0, m, 0);
      cnt += int'(dv0);
    end
    chk(cnt == (bl == 66 ? 32 : 64), "R4 payload cycles per window", 64'(cnt), 64'(bl == 66 ? 32 : 64));
    // R5 single pulse
    cyc(0, m, 1);
    cyc(0, m, 0);
    repeat (20) cyc(0, m, 0);
    // R6 held request
    pb = int'(p0);
    repeat (6) cyc(0, m, 1);
    cyc(0, m, 0);
    chk(int'(p0) == (pb + 1) % bl, "R6 held slip gives one shift", 64'(p0), 64'((pb + 1) % bl));
    repeat (10) cyc(0, m, 0);
    // R7 full wrap
    pb = int'(p0);
    repeat (bl) begin
      cyc(0, m, 1);
      cyc(0, m, 0);
    end
    chk(int'(p0) == pb, "R7 wrap after one block length of slips", 64'(p0), 64'(pb));
    repeat (40) cyc(0, m, ($urandom % 5) == 0);
    // R9 reset mid-stream
    cyc(1, m, 1);
    chk(!dv0 && !hv0 && p0 == 0 && d0 == 0, "R9 reset clears outputs", {d0[62:0], dv0}, 64'd0);
    repeat (30) cyc(0, m, 0);
  endtask

  initial begin
    rst = 1; mode67 = 0; slip = 0; din64 = '0; din32 = '0; last_rst = 1;
    @(negedge clk);
    run_mode(1'b0);
    run_mode(1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule